// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (I2C). A host uses it to read and write a small bank of configuration registers, and the block decides when those registers are copied into a nonvolatile store. SDA and SCL are sampled with the system clock. The block finds START, repeated START and STOP conditions on the sampled lines. It answers only to a 7-bit device address. The upper four bits of that address are the fixed pattern `1011`, and the lower three bits come from a programmable register. After the device address, the host sends one index byte, which names a register or carries a command. Data bytes follow, going in either direction.

The nonvolatile array is modelled as a busy timer. A commit request starts the timer. While the timer runs, the slave refuses all traffic by not acknowledging. A write-control bit chooses between two commit policies: commit after every register write, or commit only when a dedicated command byte arrives. A write to the address register always commits, whatever that bit says.

The prescaler register drives three decoded outputs: output level in power-down, dither depth, and divide exponent. The address register drives the write-control bit and the three device-address bits.

Top module: `i2c_cfg_regbank`

## Requirements
- R1: A START is a high-to-low SDA change while SCL is high. A STOP is a low-to-high SDA change while SCL is high. A START seen in any state, including partway through a transfer, restarts the address phase. A STOP returns the slave to idle with SDA released. The slave changes its SDA drive only while the sampled SCL is low.
- R2: The first byte is read MSB first as `1011`, then three device-address bits, then R/W (1 = read). The slave acknowledges (drives SDA low in the ninth clock) only when those three bits equal bits 2:0 of the address register. Otherwise it does not drive SDA until the next START.
- R3: In a write, the slave acknowledges the device address, the index byte and every data byte. Each data byte is stored at the current index, and the index then advances by one.
- R4: A read is a write of the index byte, then a repeated START with R/W = 1. The slave sends bytes MSB first and advances the index after each one. When the host answers a byte with NACK (SDA high in the ninth clock), the slave releases SDA so the host can send STOP.
- R5: The prescaler register is at index 02h. Bit 5 sets the power-down output level (1 = drive low), bit 4 sets the dither depth (1 = narrow), and bits 3:0 set the divide exponent. An exponent above 8 is output as 8. Bits 7:6 are not stored and read as 0.
- R6: The address register is at index 08h. Bit 3 is the write-control bit and bits 2:0 are the device-address bits. Bits 7:4 read as 0.
- R7: With write control at 0 (the reset value), every write to an implemented register raises `nv_commit` for one cycle.
- R8: With write control at 1, writes to the prescaler do not commit. The index byte A5h (the commit command) raises `nv_commit` for one cycle.
- R9: A write to the address register raises `nv_commit` whatever the write-control bit holds.
- R10: After a commit, `nv_busy` stays high for exactly COMMIT_CYCLES cycles. While `nv_busy` is high, the slave does not acknowledge any byte and stores nothing.
- R11: A data byte written to an unimplemented index is acknowledged, discarded and never committed. A read of an unimplemented index returns 00h.
- R12: After reset, SDA is released, `nv_busy` and `nv_commit` are low, and both registers hold their reset values (all zero by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the open-drain data line low |
| out_drive_low | output | 1 | Prescaler bit 5: output level in power-down |
| dither_narrow | output | 1 | Prescaler bit 4: narrow dither depth |
| div_exp | output | 4 | Divide exponent, saturated at 8 |
| wr_ctrl | output | 1 | Write-control bit of the address register |
| dev_addr | output | 3 | Device-address bits of the address register |
| nv_commit | output | 1 | One-cycle request to copy the registers to the store |
| nv_busy | output | 1 | Store write in progress |

## Verification
On every cycle, the assertions check three things. SDA drive changes only while SCL is low. A STOP always leaves the slave idle with SDA released. SDA is let go after a host NACK. They also check the commit handshake: a request never arrives while the store is busy, and busy follows each request. The address byte is never acknowledged while the store is busy, and a stored register changes only on a write strobe. The scenarios cover the rest. They show address matching against a reprogrammed device address, and byte order and index auto-increment in both directions. They show both write-control policies, the command byte and the forced commit on address-register writes, saturation of the exponent, and how unimplemented indices behave.

// File: rtl/i2c_cfg_pkg.sv
// Package: types and constants shared by the configuration slave.
// Assumes the bus is sampled by a clock much faster than SCL.
package i2c_cfg_pkg;

    // Fixed upper nibble of the device address.
    localparam logic [3:0] DEV_ID = 4'b1011;

    // Bits per byte on the bus.
    localparam logic [3:0] BYTE_BITS = 4'd8;

    // Byte engine states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Bus line sampler: synchronizes SCL and SDA into the clock domain and
// derives SCL edges plus START and STOP events from the synchronized values.
// Assumes STAGES >= 2 and SCL phases several clocks long.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prev;
    logic              sda_prev;

    // Synchronizer chains; an idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // One-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Event decode from current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/i2c_cfg_fsm.sv
// Byte engine: frames bytes between sampled SCL edges, matches the device
// address, holds the register index, drives ACK and read data on SDA and
// raises write strobes and commit requests. Assumes events come from
// i2c_line_sync and that the index selects rd_data combinationally.
module i2c_cfg_fsm
    import i2c_cfg_pkg::*;
#(
    parameter logic [7:0] PRESC_IDX  = 8'h02,
    parameter logic [7:0] ADDR_IDX   = 8'h08,
    parameter logic [7:0] CMD_COMMIT = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [2:0] dev_addr,
    input  logic       wr_ctrl,
    input  logic       nv_busy,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_idx,
    output logic       wr_valid,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       commit_req,
    output logic       sda_oe
);

    slv_state_t state;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [6:0] tx_sh;
    logic [7:0] ptr;
    logic       rw;
    logic       addr_match;
    logic       ptr_impl;

    // Address compare and implemented-index decode.
    always_comb begin
        addr_match = (rx_sh[7:1] == {DEV_ID, dev_addr});
        ptr_impl   = (ptr == PRESC_IDX) || (ptr == ADDR_IDX);
    end

    assign rd_idx = ptr;

    // Protocol sequencing, one SCL event at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            ptr        <= '0;
            rw         <= 1'b0;
            sda_oe     <= 1'b0;
            wr_valid   <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
            commit_req <= 1'b0;
        end else begin
            wr_valid   <= 1'b0;
            commit_req <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_REG, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == BYTE_BITS) begin
                            if (nv_busy) begin
                                state <= ST_IDLE;
                            end else if (state == ST_ADDR) begin
                                if (addr_match) begin
                                    sda_oe <= 1'b1;
                                    rw     <= rx_sh[0];
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_REG) begin
                                ptr    <= rx_sh;
                                sda_oe <= 1'b1;
                                state  <= ST_REG_ACK;
                                if (rx_sh == CMD_COMMIT) commit_req <= 1'b1;
                            end else begin
                                wr_valid <= 1'b1;
                                wr_idx   <= ptr;
                                wr_data  <= rx_sh;
                                ptr      <= ptr + 8'd1;
                                sda_oe   <= 1'b1;
                                state    <= ST_WDATA_ACK;
                                if (ptr_impl && (ptr == ADDR_IDX || !wr_ctrl))
                                    commit_req <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                tx_sh  <= rd_data[6:0];
                                sda_oe <= ~rd_data[7];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_REG;
                            end
                        end
                    end
                    ST_REG_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b0;
                            state   <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == BYTE_BITS) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 8'd1;
                                state  <= ST_RDATA_ACK;
                            end else begin
                                sda_oe <= ~tx_sh[6];
                                tx_sh  <= {tx_sh[5:0], 1'b0};
                            end
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (scl_rise && sda_s) begin
                            state <= ST_IDLE;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            tx_sh   <= rd_data[6:0];
                            sda_oe  <= ~rd_data[7];
                            state   <= ST_RDATA;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R1: a STOP leaves the engine idle and the line released.
    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R1: the slave moves SDA only while SCL is low.
    p_sda_change_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R4: a host NACK makes the slave let go of SDA.
    p_nack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA_ACK && scl_rise && sda_s) |=> !sda_oe);

    // R10: no address acknowledge while the store is busy.
    p_busy_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bit_cnt == BYTE_BITS && nv_busy) |=> !sda_oe);

endmodule

// File: rtl/cfg_regfile.sv
// Register bank: holds the prescaler and address registers, serves reads
// by index and decodes the register fields onto outputs. Assumes one write
// strobe per data byte; unimplemented indices read as zero.
module cfg_regfile #(
    parameter logic [7:0] PRESC_IDX = 8'h02,
    parameter logic [7:0] ADDR_IDX  = 8'h08,
    parameter logic [5:0] PRESC_RST = 6'h00,
    parameter logic [3:0] ADDR_RST  = 4'h0,
    parameter int         MAX_EXP   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data,
    output logic       out_drive_low,
    output logic       dither_narrow,
    output logic [3:0] div_exp,
    output logic       wr_ctrl,
    output logic [2:0] dev_addr
);

    localparam logic [3:0] EXP_CAP = 4'(MAX_EXP);

    logic [5:0] presc_q;
    logic [3:0] addr_q;
    logic       unused_hi;

    assign unused_hi = ^wr_data[7:6];

    // Indexed register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= PRESC_RST;
            addr_q  <= ADDR_RST;
        end else if (wr_valid) begin
            if (wr_idx == PRESC_IDX) presc_q <= wr_data[5:0];
            if (wr_idx == ADDR_IDX)  addr_q  <= wr_data[3:0];
        end
    end

    // Read mux; anything unmapped returns zero.
    always_comb begin
        if (rd_idx == PRESC_IDX)     rd_data = {2'b00, presc_q};
        else if (rd_idx == ADDR_IDX) rd_data = {4'h0, addr_q};
        else                         rd_data = 8'h00;
    end

    // Field decode with saturating exponent.
    always_comb begin
        out_drive_low = presc_q[5];
        dither_narrow = presc_q[4];
        div_exp       = (presc_q[3:0] > EXP_CAP) ? EXP_CAP : presc_q[3:0];
        wr_ctrl       = addr_q[3];
        dev_addr      = addr_q[2:0];
    end

    // R5: the prescaler holds its value between write strobes.
    p_presc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(presc_q));

endmodule

// File: rtl/nv_commit_timer.sv
// Store model: a commit request starts a down-counter, and busy is shown
// for exactly COMMIT_CYCLES cycles. Assumes requests arrive only while idle.
module nv_commit_timer #(
    parameter int COMMIT_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit_req,
    output logic busy
);

    localparam int CW = $clog2(COMMIT_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(COMMIT_CYCLES);

    logic [CW-1:0] remain;

    // Load on request, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)               remain <= '0;
        else if (commit_req)      remain <= LOAD;
        else if (remain != '0)    remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R10: the byte engine never requests while the store is busy.
    p_req_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> !busy);

    // R10: busy follows every request.
    p_busy_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |=> busy);

endmodule

// File: rtl/i2c_cfg_regbank.sv
// Top: two-wire configuration slave with commit policy and store busy model.
// Assumes an external open-drain pad: sda_oe=1 pulls the line low.
module i2c_cfg_regbank #(
    parameter int         SYNC_STAGES   = 2,
    parameter int         COMMIT_CYCLES = 2500,
    parameter logic [7:0] PRESC_IDX     = 8'h02,
    parameter logic [7:0] ADDR_IDX      = 8'h08,
    parameter logic [7:0] CMD_COMMIT    = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       out_drive_low,
    output logic       dither_narrow,
    output logic [3:0] div_exp,
    output logic       wr_ctrl,
    output logic [2:0] dev_addr,
    output logic       nv_commit,
    output logic       nv_busy
);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_idx, rd_data, wr_idx, wr_data;
    logic       wr_valid;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_cfg_fsm #(.PRESC_IDX(PRESC_IDX), .ADDR_IDX(ADDR_IDX), .CMD_COMMIT(CMD_COMMIT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .dev_addr(dev_addr), .wr_ctrl(wr_ctrl), .nv_busy(nv_busy),
        .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
        .commit_req(nv_commit), .sda_oe(sda_oe)
    );

    cfg_regfile #(.PRESC_IDX(PRESC_IDX), .ADDR_IDX(ADDR_IDX)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .out_drive_low(out_drive_low), .dither_narrow(dither_narrow),
        .div_exp(div_exp), .wr_ctrl(wr_ctrl), .dev_addr(dev_addr)
    );

    nv_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_nv (
        .clk(clk), .rst_n(rst_n), .commit_req(nv_commit), .busy(nv_busy)
    );

endmodule

// File: tb/i2c_cfg_regbank_tb_top.sv
// Scoreboard bench: bus tasks push expected ACK levels and read bytes;
// a monitor process pops and compares them against observed values.
module i2c_cfg_regbank_tb_top;

    localparam int Q    = 10;
    localparam int BUSY = 1500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line;
    logic sda_oe, out_drive_low, dither_narrow, wr_ctrl, nv_commit, nv_busy;
    logic [3:0] div_exp;
    logic [2:0] dev_addr;

    assign sda_line = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    i2c_cfg_regbank #(.COMMIT_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .out_drive_low(out_drive_low), .dither_narrow(dither_narrow),
        .div_exp(div_exp), .wr_ctrl(wr_ctrl), .dev_addr(dev_addr),
        .nv_commit(nv_commit), .nv_busy(nv_busy)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    commits = 0;
    bit    done = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    int    obs_q[$];
    int    m_obs, m_exp;
    string m_tag;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_item(string tag, int v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    // Monitor: compare observations against expectations in order.
    always @(negedge clk) begin
        if (obs_q.size() > 0) begin
            m_obs = obs_q.pop_front();
            if (exp_q.size() > 0) begin
                m_exp = exp_q.pop_front();
                m_tag = tag_q.pop_front();
                chk(m_tag, m_obs, m_exp);
            end else begin
                chk("scoreboard underflow", m_obs, -1);
            end
        end
    end

    // Commit pulse counter.
    always @(posedge clk) if (rst_n && nv_commit) commits++;

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    // Send a byte; observed ACK level (0 = ACK) goes to the scoreboard.
    task automatic send_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        obs_q.push_back(int'(sda_line));
        wq();
        m_scl = 1'b0; wq();
    endtask

    // Receive a byte into the scoreboard, then answer ACK or NACK.
    task automatic recv_byte(bit host_ack, string tag);
        logic [7:0] b;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i] = sda_line; wq();
            m_scl = 1'b0;
        end
        obs_q.push_back(int'(b));
        wq();
        m_sda = host_ack ? 1'b0 : 1'b1; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        if (!host_ack) chk({tag, " SDA released after host NACK"}, int'(sda_oe), 0);
    endtask

    task automatic write1(logic [2:0] a, logic [7:0] idx, logic [7:0] v, string tag);
        expect_item({tag, " addr ack"}, 0);
        expect_item({tag, " index ack"}, 0);
        expect_item({tag, " data ack"}, 0);
        bus_start();
        send_byte({4'b1011, a, 1'b0});
        send_byte(idx);
        send_byte(v);
        bus_stop();
    endtask

    task automatic addr_only(logic [7:0] b, int exp_lvl, string tag);
        expect_item(tag, exp_lvl);
        bus_start();
        send_byte(b);
        bus_stop();
    endtask

    task automatic settle();
        repeat (BUSY + 100) @(negedge clk);
    endtask

    initial begin
        int c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12: reset state.
        chk("R12 sda_oe", int'(sda_oe), 0);
        chk("R12 nv_busy", int'(nv_busy), 0);
        chk("R12 div_exp", int'(div_exp), 0);
        chk("R12 wr_ctrl", int'(wr_ctrl), 0);
        chk("R12 dev_addr", int'(dev_addr), 0);

        // R3 R5 R7: write 3Bh to the prescaler, exponent 11 saturates at 8.
        c0 = commits;
        write1(3'd0, 8'h02, 8'h3B, "R3");
        chk("R7 commit on write, WC=0", commits - c0, 1);
        chk("R5 drive-low bit", int'(out_drive_low), 1);
        chk("R5 narrow dither bit", int'(dither_narrow), 1);
        chk("R5 exponent saturates", int'(div_exp), 8);
        chk("R10 busy after commit", int'(nv_busy), 1);

        // R10: address byte refused while busy.
        addr_only(8'hB0, 1, "R10 NACK while busy");
        settle();
        chk("R10 busy cleared", int'(nv_busy), 0);

        // R4 R11: read prescaler, then unimplemented 03h, host NACKs.
        expect_item("R4 addr ack", 0);
        expect_item("R4 index ack", 0);
        expect_item("R4 read addr ack", 0);
        expect_item("R4 prescaler readback", 8'h3B);
        expect_item("R11 unimplemented reads 00h", 8'h00);
        bus_start();
        send_byte(8'hB0);
        send_byte(8'h02);
        bus_rstart();
        send_byte(8'hB1);
        recv_byte(1'b1, "R4");
        recv_byte(1'b0, "R4");
        bus_stop();

        // R2: wrong device-address bits.
        addr_only(8'hB2, 1, "R2 mismatch NACK");

        // R6 R9: address register = 0Bh (WC=1, address 3), commits.
        c0 = commits;
        write1(3'd0, 8'h08, 8'h0B, "R6");
        chk("R9 address write commits", commits - c0, 1);
        chk("R6 wr_ctrl", int'(wr_ctrl), 1);
        chk("R6 dev_addr", int'(dev_addr), 3);
        settle();

        // R2: old address no longer matches.
        addr_only(8'hB0, 1, "R2 old address NACK");

        // R8 R11 R3: WC=1, write C5h to 02h then 77h to 03h, no commit.
        c0 = commits;
        expect_item("R3 addr ack", 0);
        expect_item("R3 index ack", 0);
        expect_item("R3 data ack", 0);
        expect_item("R11 unimplemented write ack", 0);
        bus_start();
        send_byte(8'hB6);
        send_byte(8'h02);
        send_byte(8'hC5);
        send_byte(8'h77);
        bus_stop();
        chk("R8 no commit with WC=1", commits - c0, 0);
        chk("R11 no commit on unimplemented", int'(nv_busy), 0);
        chk("R5 exponent 5", int'(div_exp), 5);
        chk("R5 bit5 clear", int'(out_drive_low), 0);

        // R8: commit command byte.
        c0 = commits;
        expect_item("R8 addr ack", 0);
        expect_item("R8 command ack", 0);
        bus_start();
        send_byte(8'hB6);
        send_byte(8'hA5);
        bus_stop();
        chk("R8 command commits", commits - c0, 1);
        settle();

        // R9: address write with WC=1 still commits; address back to 0.
        c0 = commits;
        write1(3'd3, 8'h08, 8'h08, "R9");
        chk("R9 commit with WC=1", commits - c0, 1);
        chk("R6 dev_addr 0", int'(dev_addr), 0);
        settle();

        // R5 R6: read back 02h (upper bits dropped) and 08h.
        expect_item("R5 addr ack", 0);
        expect_item("R5 index ack", 0);
        expect_item("R5 read addr ack", 0);
        expect_item("R5 upper bits read 0", 8'h05);
        bus_start();
        send_byte(8'hB0);
        send_byte(8'h02);
        bus_rstart();
        send_byte(8'hB1);
        recv_byte(1'b0, "R4");
        bus_stop();
        expect_item("R6 addr ack", 0);
        expect_item("R6 index ack", 0);
        expect_item("R6 read addr ack", 0);
        expect_item("R6 readback", 8'h08);
        bus_start();
        send_byte(8'hB0);
        send_byte(8'h08);
        bus_rstart();
        send_byte(8'hB1);
        recv_byte(1'b0, "R4");
        bus_stop();

        // R1: repeated START after the index byte restarts a write.
        expect_item("R1 addr ack", 0);
        expect_item("R1 index ack", 0);
        expect_item("R1 restart addr ack", 0);
        expect_item("R1 restart index ack", 0);
        expect_item("R1 restart data ack", 0);
        bus_start();
        send_byte(8'hB0);
        send_byte(8'h02);
        bus_rstart();
        send_byte(8'hB0);
        send_byte(8'h02);
        send_byte(8'h21);
        bus_stop();
        chk("R1 exponent after restart", int'(div_exp), 1);
        chk("R1 drive-low after restart", int'(out_drive_low), 1);
        chk("R1 released after STOP", int'(sda_oe), 0);

        repeat (5) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule